// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and a short shift register of recent branch outcomes. The counter used for a branch is picked by an index built from the branch address and that outcome history. A lookup port gives a prediction for a fetch address in the same cycle, with no register on the path. An update port takes resolved branches as they retire: it trains the selected counter and then pushes the outcome into the history.

A parameter picks how the index is built. In joining mode, a chosen number of the newest history bits sit above the low address bits. With zero history bits this is a pure per-address table, and with all index bits taken from history it is a pure global-history table. In folding mode, the address bits are XORed with the whole history. This keeps every history bit in play even when the table is small. The table has no tags, so branches that map to one entry share its counter.

Top module: `gbp_predictor`

## Requirements
- R1: Each counter is a two-bit value from 0 to 3. A taken update raises it by one and a not-taken update lowers it by one. A taken update at 3 leaves it at 3, and a not-taken update at 0 leaves it at 0.
- R2: `lk_taken` is 1 when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R3: The history register is `HIST_W` bits wide. Each valid update shifts it left by one and puts the outcome into bit 0 (1 = taken, 0 = not taken). Bit 0 therefore always holds the most recent outcome.
- R4: When `MODE` is `IDX_CAT`, the index is `{hist[CAT_HIST-1:0], pc[PC_LSB +: IDX_W-CAT_HIST]}`, with the history bits in the upper part.
- R5: When `MODE` is `IDX_CAT` and `CAT_HIST` is 0, the history has no effect: the index is `pc[PC_LSB +: IDX_W]`.
- R6: When `MODE` is `IDX_XOR`, the index is `pc[PC_LSB +: IDX_W]` XOR the history, with the history zero-extended to `IDX_W` bits (`HIST_W <= IDX_W`).
- R7: There is no tag check. Two addresses that produce the same index read and train the same counter.
- R8: A synchronous active-high `rst` sets every counter to 0 (predict not taken) and clears the history to 0.
- R9: An update trains the counter at the index formed from `up_pc` and the history value from before this update's shift.
- R10: The lookup result is combinational from `lk_pc` and the current state. When a lookup and an update hit the same entry in the same cycle, the lookup returns the value from before the update.
- R11: When `up_valid` is 0, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
Three instances share one stimulus stream: a joining instance with two history bits, a folding instance, and a pure per-address instance. A reference model of each instance is updated in step with the stimulus, and the bench compares every prediction against it.

Long runs of one outcome on a single branch reach both saturation limits. One extra opposite outcome then shows whether the counter wrapped or flipped too early. An alternating taken/not-taken branch separates the instances: the history-indexed ones learn a separate counter for each phase, while the per-address one keeps one blended counter. Addresses that differ only above the index bits expose any hidden tag. A lookup placed in the same cycle as its own update, and idle cycles between updates, show the read-before-write order and that nothing changes without a valid update.

// File: rtl/gbp_pkg.sv
`timescale 1ns/1ps
package gbp_pkg;

    typedef logic [1:0] ctr_t;

    typedef enum logic {
        IDX_CAT = 1'b0,
        IDX_XOR = 1'b1
    } idx_mode_e;

    localparam ctr_t CTR_LO   = 2'b00;
    localparam ctr_t CTR_HI   = 2'b11;
    localparam ctr_t CTR_INIT = CTR_LO;

    // saturating step toward the observed outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_HI) ? CTR_HI : ctr_t'(cur + 2'd1);
        else
            nxt = (cur == CTR_LO) ? CTR_LO : ctr_t'(cur - 2'd1);
        return nxt;
    endfunction

    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gbp_index.sv
`timescale 1ns/1ps
module gbp_index
    import gbp_pkg::*;
#(
    parameter idx_mode_e MODE     = IDX_CAT,
    parameter int        IDX_W    = 6,
    parameter int        HIST_W   = 4,
    parameter int        CAT_HIST = 2
) (
    input  logic [IDX_W-1:0]  pc_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int ADDR_W = IDX_W - CAT_HIST;

    generate
        if (MODE == IDX_XOR) begin : g_fold
            always_comb idx = pc_bits ^ IDX_W'(hist);
        end else if (CAT_HIST == 0) begin : g_addr_only
            logic unused_hist;
            always_comb unused_hist = ^hist;
            always_comb idx = pc_bits;
        end else if (CAT_HIST >= IDX_W) begin : g_hist_only
            always_comb idx = hist[IDX_W-1:0];
        end else begin : g_join
            always_comb idx = {hist[CAT_HIST-1:0], pc_bits[ADDR_W-1:0]};
        end
    endgenerate

endmodule

// File: rtl/gbp_history.sv
`timescale 1ns/1ps
module gbp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (shift_en)
            hist <= HIST_W'({hist, outcome});
    end
endmodule

// File: rtl/gbp_table.sv
`timescale 1ns/1ps
module gbp_table
    import gbp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr_t             rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr_t             rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_t             wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= CTR_INIT;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    always_comb rd_a = cells[rd_a_idx];
    always_comb rd_b = cells[rd_b_idx];
endmodule

// File: rtl/gbp_predictor.sv
`timescale 1ns/1ps
module gbp_predictor
    import gbp_pkg::*;
#(
    parameter idx_mode_e MODE     = IDX_CAT,
    parameter int        PC_W     = 16,
    parameter int        PC_LSB   = 2,
    parameter int        IDX_W    = 6,
    parameter int        HIST_W   = 4,
    parameter int        CAT_HIST = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    ctr_t              lk_ctr;
    ctr_t              up_old;
    ctr_t              up_new;

    gbp_index #(.MODE(MODE), .IDX_W(IDX_W), .HIST_W(HIST_W), .CAT_HIST(CAT_HIST)) u_lk_idx (
        .pc_bits (lk_pc[PC_LSB +: IDX_W]),
        .hist    (hist),
        .idx     (lk_idx)
    );

    gbp_index #(.MODE(MODE), .IDX_W(IDX_W), .HIST_W(HIST_W), .CAT_HIST(CAT_HIST)) u_up_idx (
        .pc_bits (up_pc[PC_LSB +: IDX_W]),
        .hist    (hist),
        .idx     (up_idx)
    );

    gbp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_idx),
        .rd_a     (lk_ctr),
        .rd_b_idx (up_idx),
        .rd_b     (up_old),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_val   (up_new)
    );

    gbp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist     (hist)
    );

    always_comb up_new   = ctr_step(up_old, up_taken);
    always_comb lk_taken = ctr_dir(lk_ctr);

endmodule

// File: rtl/gbp_predictor_chk.sv
`timescale 1ns/1ps
module gbp_predictor_chk
    import gbp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_taken,
    input logic [IDX_W-1:0]  up_idx,
    input ctr_t              up_old,
    input logic [IDX_W-1:0]  lk_idx,
    input ctr_t              lk_ctr,
    input logic [HIST_W-1:0] hist
);
    // R3: outcome enters at bit 0, older bits move up
    p_hist_shift_r3: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> hist == HIST_W'({$past(hist), $past(up_taken)}));

    // R11: history frozen without a valid update
    p_hist_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(hist));

    // R11: a watched entry keeps its value across an idle cycle
    p_ctr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!up_valid) && lk_idx == $past(lk_idx)) |-> $stable(lk_ctr));

    // R1: no wrap at the top
    p_sat_top_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && up_taken && up_old == 2'b11) && lk_idx == $past(up_idx))
        |-> lk_ctr == 2'b11);

    // R1: no wrap at the bottom
    p_sat_bot_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && !up_taken && up_old == 2'b00) && lk_idx == $past(up_idx))
        |-> lk_ctr == 2'b00);

    // R1: a taken update below the top raises the stored value by one
    p_step_up_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && up_taken && up_old != 2'b11) && lk_idx == $past(up_idx))
        |-> lk_ctr == ctr_t'($past(up_old) + 2'd1));
endmodule

bind gbp_predictor gbp_predictor_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .up_idx   (up_idx),
    .up_old   (up_old),
    .lk_idx   (lk_idx),
    .lk_ctr   (lk_ctr),
    .hist     (hist)
);

// File: tb/gbp_predictor_test.sv
`timescale 1ns/1ps
module gbp_predictor_test;
    import gbp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic [15:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        t_cat, t_xor, t_bim;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference state: 0 = joining (2 history bits), 1 = folding, 2 = per-address
    int       ref_ctr [3][64];
    logic [3:0] ref_hist [3];

    always #2.5 clk = ~clk;

    gbp_predictor #(.MODE(IDX_CAT), .PC_W(16), .PC_LSB(2), .IDX_W(6), .HIST_W(4), .CAT_HIST(2)) uut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t_cat),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    gbp_predictor #(.MODE(IDX_XOR), .PC_W(16), .PC_LSB(2), .IDX_W(6), .HIST_W(4), .CAT_HIST(2)) uut_xor (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t_xor),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    gbp_predictor #(.MODE(IDX_CAT), .PC_W(16), .PC_LSB(2), .IDX_W(6), .HIST_W(4), .CAT_HIST(0)) uut_bim (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(t_bim),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    function automatic int ref_idx(int k, logic [15:0] pc, logic [3:0] h);
        logic [5:0] p;
        p = pc[7:2];
        case (k)
            0:       return int'({h[1:0], p[3:0]});   // R4
            1:       return int'(p ^ {2'b00, h});     // R6
            default: return int'(p);                  // R5
        endcase
    endfunction

    function automatic logic got_of(int k);
        case (k)
            0:       return t_cat;
            1:       return t_xor;
            default: return t_bim;
        endcase
    endfunction

    task automatic expect_all(input logic [15:0] pc, input string req);
        lk_pc = pc;
        #0.5;
        for (int k = 0; k < 3; k++) begin
            logic exp_t;
            exp_t = (ref_ctr[k][ref_idx(k, pc, ref_hist[k])] >= 2);   // R2
            checks++;
            if (got_of(k) !== exp_t) begin
                errors++;
                $display("FAIL %s inst%0d pc=%h actual=%b expected=%b", req, k, pc, got_of(k), exp_t);
            end
        end
    endtask

    task automatic model_update(input logic [15:0] pc, input logic tk);
        for (int k = 0; k < 3; k++) begin
            int i;
            i = ref_idx(k, pc, ref_hist[k]);                           // R9: pre-shift history
            if (tk)  ref_ctr[k][i] = (ref_ctr[k][i] == 3) ? 3 : ref_ctr[k][i] + 1;
            else     ref_ctr[k][i] = (ref_ctr[k][i] == 0) ? 0 : ref_ctr[k][i] - 1;
            ref_hist[k] = {ref_hist[k][2:0], tk};                      // R3
        end
    endtask

    // one update; optional lookup of the same address before the edge (R10)
    task automatic do_update(input logic [15:0] pc, input logic tk, input bit probe);
        @(negedge clk);
        up_valid = 1'b1;
        up_pc    = pc;
        up_taken = tk;
        if (probe) expect_all(pc, "R10 same-cycle lookup");
        @(posedge clk);
        #0.5;
        up_valid = 1'b0;
        model_update(pc, tk);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 3; k++) begin
            ref_hist[k] = '0;
            for (int i = 0; i < 64; i++) ref_ctr[k][i] = 0;
        end
        @(negedge clk);
        expect_all(16'h0000, "R8 reset");
        expect_all(16'h0104, "R8 reset");
        expect_all(16'h00fc, "R8 reset");
    endtask

    task automatic t_saturate;
        for (int n = 0; n < 6; n++) begin
            do_update(16'h0040, 1'b1, 0);
            @(negedge clk); expect_all(16'h0040, "R1 R2 up run");
        end
        do_update(16'h0040, 1'b0, 0);
        @(negedge clk); expect_all(16'h0040, "R1 one not-taken after saturation");
        for (int n = 0; n < 7; n++) begin
            do_update(16'h0040, 1'b0, 0);
            @(negedge clk); expect_all(16'h0040, "R1 R2 down run");
        end
        do_update(16'h0040, 1'b1, 0);
        @(negedge clk); expect_all(16'h0040, "R1 one taken after floor");
    endtask

    task automatic t_alternate;
        for (int n = 0; n < 16; n++) begin
            do_update(16'h0088, n[0], 0);
            @(negedge clk);
            expect_all(16'h0088, "R3 R4 R5 R6 alternating");
        end
    endtask

    task automatic t_history_mix;
        for (int n = 0; n < 12; n++) begin
            do_update(16'h0010 + 16'(n * 4), (n % 3) != 0, 0);
            @(negedge clk);
            expect_all(16'h0014, "R5 R6 R9 mixed branches");
            expect_all(16'h0030, "R4 R9 mixed branches");
        end
    endtask

    task automatic t_alias;
        for (int n = 0; n < 4; n++) do_update(16'h0124, 1'b1, 0);
        @(negedge clk);
        expect_all(16'h0024, "R7 alias low copy");
        expect_all(16'hff24, "R7 alias high copy");
    endtask

    task automatic t_same_cycle;
        do_update(16'h0200, 1'b0, 1);
        do_update(16'h0050, 1'b1, 1);
        do_update(16'h0050, 1'b1, 1);
        do_update(16'h0050, 1'b1, 1);
        do_update(16'h0050, 1'b0, 1);
        @(negedge clk); expect_all(16'h0050, "R10 after writes");
    endtask

    task automatic t_idle;
        @(negedge clk);
        up_pc = 16'h0050; up_taken = 1'b1;   // presented but not valid
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            expect_all(16'h0050, "R11 idle hold");
            expect_all(16'h0040, "R11 idle hold");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        t_reset();
        t_saturate();
        t_alternate();
        t_history_mix();
        t_alias();
        t_same_cycle();
        t_idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule